// File: doc/BRIEF.md
# Pulse Width Measurement Counter

This block times one external digital input against a selectable internal tick. After the input passes through a short synchronizer, a 16-bit up-counter runs between a start edge and an end edge. The edges depend on the measurement type: a high phase, a low phase, one rising-to-rising interval, or a span of several rising edges set by a programmable ratio. At the end edge the count goes into a data buffer and a sticky completion flag is set. If the counter wraps past its maximum while it runs, a separate sticky overflow flag is set. The same counter can also serve as a plain periodic timer whose period comes from a reload value.

Software sees four registers through a simple write port and a combinational read port: a control word, a divide ratio, the data buffer and a status word. The clock enables that set the tick period come from a prescaler outside the block. Each enable is a one-cycle strobe, and a control field picks which of them drives the counter. Two level outputs, gated by enable bits in the control word, carry the completion and overflow requests to an interrupt controller.

A measurement runs once or repeatedly. In the single mode the block returns to idle after the first result and ignores later edges. In the repeating mode it moves to the next measurement at once and needs no software action.

Top module: `pulse_meter`

## Requirements
- R1: After reset the data buffer (address 2), the status word (address 3) and both request outputs read zero, and the block is idle.
- R2: Mode code 1 measures a high phase. Counting starts at a synchronized rising edge and stops at the following falling edge. With a tick on every clock, a high phase of W clocks gives a result of W.
- R3: Mode code 2 measures a low phase. It starts at a falling edge, ends at the next rising edge, and gives the length of the low phase in ticks.
- R4: Mode code 3 measures the interval between two successive rising edges in ticks.
- R5: Mode code 4 measures the span from a rising edge to the D-th rising edge after it. D is the ratio held at address 1, and a ratio of 0 acts as 1.
- R6: With control bit 5 (repeat) clear, the block goes idle after the first result. Status bit 2 (busy) then reads 0, and later edges leave the data buffer unchanged.
- R7: With control bit 5 set, the block writes results one after another without being restarted. A high or low phase waits for the next start edge. An interval or a span restarts on its own ending edge.
- R8: If a tick arrives while the counter holds its maximum during a measurement, the counter wraps to zero and counting goes on. Status bit 1 then sets and stays set. The output irq_ovf equals that flag ANDed with control bit 7.
- R9: A result or a timer period sets status bit 0, which stays set. Writing 1 to that bit at address 3 clears it, but a new event in the same cycle wins. The output irq_done equals the flag ANDed with control bit 6.
- R10: Control bits 1:0 select which tick_en strobe advances the counter. The counter moves only on cycles when that strobe is high.
- R11: Mode code 0 runs a reload timer. The reload value is written to address 2. The counter counts ticks, and a tick that finds the count equal to the reload clears the counter and sets status bit 0. The period is therefore reload+1 ticks.
- R12: The control word is at address 0, with the mode code in bits 4:2. Writing it with bit 8 set starts a fresh measurement, even while one is running. Writing it with bit 8 clear stops the block, and a stopped block ignores input edges.
- R13: The input passes through SYNC_STAGES flip-flops before edges are detected. Both edges therefore see the same delay, and a result counts the ticks from the cycle after the start edge is detected up to and including the cycle of the end edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | NUM_TICKS | Prescaled tick strobes, one per selectable rate |
| sig_in | input | 1 | Signal being measured, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data, combinational |
| irq_done | output | 1 | Completion request |
| irq_ovf | output | 1 | Overflow request |

## Verification
Each measurement type is driven with input waveforms whose result is known in advance. High and low phases of different lengths check that the correct edge pair is chosen. A square wave shows the difference between one interval and a span of several edges, and between a ratio of 3 and the zero ratio that acts as 1. A tick that fires on alternate cycles, compared with one that fires on every cycle, shows that the tick select really gates counting. A phase longer than the counter range separates wrapping from saturating. A behavioural model of the block, stepped on every clock, follows both request lines throughout, so that an event set or cleared one cycle early or late is also caught.

// File: rtl/pulse_meter_pkg.sv
package pulse_meter_pkg;

   typedef enum logic [2:0] {
      MODE_TIMER   = 3'd0,
      MODE_HIGH    = 3'd1,
      MODE_LOW     = 3'd2,
      MODE_EDGE    = 3'd3,
      MODE_DIVIDED = 3'd4
   } meas_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RUN  = 2'd2
   } meas_state_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_DIV  = 2'd1;
   localparam logic [1:0] REG_DATA = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int CTL_SEL_LSB  = 0;
   localparam int CTL_SEL_W    = 2;
   localparam int CTL_MODE_LSB = 2;
   localparam int CTL_CONT     = 5;
   localparam int CTL_DIE      = 6;
   localparam int CTL_OIE      = 7;
   localparam int CTL_START    = 8;
   localparam int CTL_BITS     = 9;

   localparam int STA_DONE = 0;
   localparam int STA_OVF  = 1;
   localparam int STA_BUSY = 2;

endpackage

// File: rtl/pm_edge_detect.sv
module pm_edge_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic level,
   output logic rise,
   output logic fall
);

   if (STAGES < 1) begin : g_bad_stages
      $error("pm_edge_detect: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= sig_in;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], sig_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

endmodule

// File: rtl/pm_width_counter.sv
module pm_width_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [WIDTH-1:0] cnt,
   output logic [WIDTH-1:0] cnt_next,
   output logic             wrap
);

   if (WIDTH < 2) begin : g_bad_width
      $error("pm_width_counter: WIDTH must be at least 2");
   end

   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   logic [WIDTH-1:0] cnt_q;

   assign cnt_next = cnt_q + WIDTH'(inc);
   assign wrap     = inc && (cnt_q == CNT_MAX);
   assign cnt      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_next;
   end

   // R8: the counter wraps instead of saturating
   p_wraps_to_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == '0));

endmodule

// File: rtl/pm_edge_divider.sv
module pm_edge_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rise,
   input  logic [DIV_W-1:0] ratio,
   output logic             last
);

   if (DIV_W < 1) begin : g_bad_div
      $error("pm_edge_divider: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] seen_q;
   logic [DIV_W-1:0] eff_ratio;

   assign eff_ratio = (ratio == '0) ? DIV_W'(1) : ratio;
   assign last      = rise && (seen_q == eff_ratio - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_q <= '0;
      else if (clr)      seen_q <= '0;
      else if (rise) begin
         if (last)       seen_q <= '0;
         else            seen_q <= seen_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
   import pulse_meter_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 8,
   parameter int NUM_TICKS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_TICKS-1:0] tick_en,
   input  logic                 sig_in,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [CNT_W-1:0]     wr_data,
   input  logic [1:0]           rd_addr,
   output logic [CNT_W-1:0]     rd_data,
   output logic                 irq_done,
   output logic                 irq_ovf
);

   localparam int SEL_SLOTS = 1 << CTL_SEL_W;

   if (CNT_W < CTL_BITS) begin : g_bad_cnt
      $error("pulse_meter: CNT_W too narrow for the control word");
   end
   if (DIV_W > CNT_W) begin : g_bad_div
      $error("pulse_meter: DIV_W must not exceed CNT_W");
   end
   if (NUM_TICKS < 1 || NUM_TICKS > SEL_SLOTS) begin : g_bad_ticks
      $error("pulse_meter: NUM_TICKS out of range");
   end

   // ---------------- tick selection ----------------
   logic [SEL_SLOTS-1:0] tick_pad;
   for (genvar i = 0; i < SEL_SLOTS; i++) begin : g_tick
      if (i < NUM_TICKS) begin : g_used
         assign tick_pad[i] = tick_en[i];
      end else begin : g_unused
         assign tick_pad[i] = 1'b0;
      end
   end

   // ---------------- register state ----------------
   logic [CTL_SEL_W-1:0] sel_q;
   logic [2:0]           mode_q;
   logic                 cont_q, die_q, oie_q;
   logic [DIV_W-1:0]     div_q;
   logic [CNT_W-1:0]     data_q;
   logic                 done_q, ovf_q;
   meas_state_e          state_q, state_d;

   logic ctrl_wr, div_wr, data_wr, stat_wr;
   assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
   assign div_wr  = wr_en && (wr_addr == REG_DIV);
   assign data_wr = wr_en && (wr_addr == REG_DATA);
   assign stat_wr = wr_en && (wr_addr == REG_STAT);

   logic tick;
   assign tick = tick_pad[sel_q];

   // ---------------- edge detection ----------------
   logic lvl, rise, fall;
   pm_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (sig_in),
      .level  (lvl),
      .rise   (rise),
      .fall   (fall)
   );

   // ---------------- counter and divider ----------------
   logic [CNT_W-1:0] cnt, cnt_next;
   logic             wrap, cnt_clr, cnt_inc;
   logic             div_clr, div_rise, div_last;
   logic             in_run, in_arm, start_hit, end_hit, finish, capture;
   logic             self_restart, ovf_set;
   logic             is_timer;

   assign in_run   = (state_q == ST_RUN);
   assign in_arm   = (state_q == ST_ARM);
   assign is_timer = (mode_q == MODE_TIMER);

   pm_width_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .inc      (cnt_inc),
      .cnt      (cnt),
      .cnt_next (cnt_next),
      .wrap     (wrap)
   );

   pm_edge_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (div_clr),
      .rise  (div_rise),
      .ratio (div_q),
      .last  (div_last)
   );

   always_comb begin
      start_hit    = (mode_q == MODE_LOW) ? fall : rise;
      self_restart = 1'b1;
      case (mode_q)
         MODE_TIMER:   end_hit = tick && (cnt == data_q);
         MODE_HIGH:  begin end_hit = fall; self_restart = 1'b0; end
         MODE_LOW:   begin end_hit = rise; self_restart = 1'b0; end
         MODE_DIVIDED: end_hit = div_last;
         default:      end_hit = rise;
      endcase
   end

   assign finish   = in_run && end_hit;
   assign capture  = finish && !is_timer;
   assign ovf_set  = in_run && wrap && !(is_timer && finish);
   assign cnt_inc  = in_run && tick;
   assign cnt_clr  = ctrl_wr || (in_arm && start_hit) || finish;
   assign div_clr  = cnt_clr;
   assign div_rise = in_run && rise && (mode_q == MODE_DIVIDED);

   // ---------------- sequencing ----------------
   always_comb begin
      state_d = state_q;
      if (ctrl_wr) begin
         if (!wr_data[CTL_START])
            state_d = ST_IDLE;
         else if (wr_data[CTL_MODE_LSB +: 3] == MODE_TIMER)
            state_d = ST_RUN;
         else
            state_d = ST_ARM;
      end else if (in_arm && start_hit && !is_timer) begin
         state_d = ST_RUN;
      end else if (finish) begin
         if (!cont_q)           state_d = ST_IDLE;
         else if (self_restart) state_d = ST_RUN;
         else                   state_d = ST_ARM;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         mode_q <= MODE_TIMER;
         cont_q <= 1'b0;
         die_q  <= 1'b0;
         oie_q  <= 1'b0;
      end else if (ctrl_wr) begin
         sel_q  <= wr_data[CTL_SEL_LSB +: CTL_SEL_W];
         mode_q <= wr_data[CTL_MODE_LSB +: 3];
         cont_q <= wr_data[CTL_CONT];
         die_q  <= wr_data[CTL_DIE];
         oie_q  <= wr_data[CTL_OIE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (div_wr) div_q <= wr_data[DIV_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (capture) data_q <= cnt_next;
      else if (data_wr) data_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (finish)                          done_q <= 1'b1;
         else if (stat_wr && wr_data[STA_DONE]) done_q <= 1'b0;
         if (ovf_set)                         ovf_q <= 1'b1;
         else if (stat_wr && wr_data[STA_OVF])  ovf_q <= 1'b0;
      end
   end

   // ---------------- read mux and requests ----------------
   logic busy;
   assign busy = (state_q != ST_IDLE);

   always_comb begin
      case (rd_addr)
         REG_CTRL: rd_data = CNT_W'({busy, oie_q, die_q, cont_q, mode_q, sel_q});
         REG_DIV:  rd_data = CNT_W'(div_q);
         REG_DATA: rd_data = data_q;
         default:  rd_data = CNT_W'({busy, ovf_q, done_q});
      endcase
   end

   assign irq_done = done_q & die_q;
   assign irq_ovf  = ovf_q & oie_q;

   // ---------------- assertions ----------------
   // R6: a single-shot run halts after its result
   p_oneshot_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !cont_q && !ctrl_wr) |=> (state_q == ST_IDLE));

   // R7: repeat mode keeps the block active after a result
   p_repeat_stays_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && cont_q && !ctrl_wr) |=> (state_q != ST_IDLE));

   // R8: a wrap during a measurement raises the overflow flag
   p_overflow_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_run && tick && (cnt == '1) && !is_timer) |=> ovf_q);

   // R9: completion flag stays until written off
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(stat_wr && wr_data[STA_DONE])) |=> done_q);

   // R12: a stopped block ignores the input
   p_idle_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !ctrl_wr && !data_wr) |=> ($stable(data_q) && (state_q == ST_IDLE)));

   // R13: synchronized input gives exclusive edges
   p_edge_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

   logic unused_lvl;
   assign unused_lvl = lvl;

endmodule

// File: tb/pulse_meter_tb_top.sv
module pulse_meter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       tick_en = 4'b0001;
   logic             sig_in = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_addr = 2'd0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [1:0]       rd_addr = 2'd0;
   logic [CNT_W-1:0] rd_data;
   logic             irq_done, irq_ovf;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_meter dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sig_in(sig_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_done(irq_done), .irq_ovf(irq_ovf)
   );

   // ---------------- behavioural reference ----------------
   int s0, s1, s2;
   int m_st, m_cnt, m_div, m_data, m_done, m_ovf;
   int m_sel, m_mode, m_cont, m_die, m_oie, m_ratio;

   always @(posedge clk) begin
      int rise, fall, tk, hit, endc, fin, wrapped, nxt, eff;
      int st_n, cnt_n, div_n;
      if (!rst_n) begin
         s0 = 0; s1 = 0; s2 = 0;
         m_st = 0; m_cnt = 0; m_div = 0; m_data = 0; m_done = 0; m_ovf = 0;
         m_sel = 0; m_mode = 0; m_cont = 0; m_die = 0; m_oie = 0; m_ratio = 0;
      end else begin
         rise = (s1 != 0 && s2 == 0) ? 1 : 0;
         fall = (s1 == 0 && s2 != 0) ? 1 : 0;
         tk   = tick_en[m_sel] ? 1 : 0;
         hit  = (m_mode == 2) ? fall : rise;
         eff  = (m_ratio == 0) ? 1 : m_ratio;
         case (m_mode)
            0: endc = (tk != 0 && m_cnt == m_data) ? 1 : 0;
            1: endc = fall;
            2: endc = rise;
            4: endc = (rise != 0 && m_div + 1 == eff) ? 1 : 0;
            default: endc = rise;
         endcase
         fin     = (m_st == 2 && endc != 0) ? 1 : 0;
         wrapped = (m_st == 2 && tk != 0 && m_cnt == 65535) ? 1 : 0;
         nxt     = (m_cnt + tk) % 65536;
         st_n = m_st; cnt_n = m_cnt; div_n = m_div;
         if (m_st == 2 && tk != 0) cnt_n = nxt;
         if (m_st == 2 && m_mode == 4 && rise != 0) div_n = m_div + 1;
         if (m_st == 1 && hit != 0 && m_mode != 0) begin st_n = 2; cnt_n = 0; div_n = 0; end
         if (fin != 0) begin
            cnt_n = 0; div_n = 0;
            if (m_cont == 0) st_n = 0;
            else if (m_mode == 1 || m_mode == 2) st_n = 1;
            else st_n = 2;
         end
         if (wrapped != 0 && !(m_mode == 0 && fin != 0)) m_ovf = 1;
         else if (wr_en && wr_addr == 3 && wr_data[1]) m_ovf = 0;
         if (fin != 0) m_done = 1;
         else if (wr_en && wr_addr == 3 && wr_data[0]) m_done = 0;
         if (fin != 0 && m_mode != 0) m_data = nxt;
         else if (wr_en && wr_addr == 2) m_data = int'(wr_data);
         if (wr_en && wr_addr == 1) m_ratio = int'(wr_data[7:0]);
         if (wr_en && wr_addr == 0) begin
            m_sel = int'(wr_data[1:0]); m_mode = int'(wr_data[4:2]);
            m_cont = wr_data[5]; m_die = wr_data[6]; m_oie = wr_data[7];
            cnt_n = 0; div_n = 0;
            if (!wr_data[8]) st_n = 0;
            else st_n = (wr_data[4:2] == 3'd0) ? 2 : 1;
         end
         m_st = st_n; m_cnt = cnt_n; m_div = div_n;
         s2 = s1; s1 = s0; s0 = sig_in ? 1 : 0;
      end
   end

   // per-clock comparison of both request lines (R8, R9)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !finished) begin
            total++;
            if (irq_done !== ((m_done != 0 && m_die != 0) ? 1'b1 : 1'b0) ||
                irq_ovf  !== ((m_ovf != 0 && m_oie != 0) ? 1'b1 : 1'b0)) begin
               bad++;
               $display("FAIL R9/R8 per-clock: irq_done=%0b irq_ovf=%0b expected %0b %0b",
                        irq_done, irq_ovf, (m_done != 0 && m_die != 0), (m_ovf != 0 && m_oie != 0));
            end
         end
      end
   end

   // alternate-cycle tick on strobe 1
   initial begin
      forever begin
         @(negedge clk);
         tick_en[1] = ~tick_en[1];
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [15:0] ctl(int sel, int mode, int cont, int die, int oie, int start);
      return 16'(sel | (mode << 2) | (cont << 5) | (die << 6) | (oie << 7) | (start << 8));
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_reg(input logic [1:0] a, input logic [15:0] mask,
                            input logic [15:0] exp, input string req);
      rd_addr = a;
      #1;
      total++;
      if ((rd_data & mask) !== exp) begin
         bad++;
         $display("FAIL %s: addr %0d actual %0h expected %0h", req, a, rd_data & mask, exp);
      end
   endtask

   task automatic check_bit(input logic act, input logic exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      @(negedge clk);
      sig_in = v;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int k;
      repeat (3) @(negedge clk);
      // R1 reset state
      check_reg(2'd2, 16'hFFFF, 16'h0000, "R1 data");
      check_reg(2'd3, 16'hFFFF, 16'h0000, "R1 status");
      check_bit(irq_done, 1'b0, "R1 irq_done");
      check_bit(irq_ovf, 1'b0, "R1 irq_ovf");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_reg(2'd3, 16'hFFFF, 16'h0000, "R1 status after release");

      // R2 high width, single shot
      wr(2'd0, ctl(0, 1, 0, 1, 0, 1));
      settle();
      hold(1'b1, 10); hold(1'b0, 4);
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd10, "R2 high width");
      check_reg(2'd3, 16'h0005, 16'h0001, "R6 done set, busy clear");
      check_bit(irq_done, 1'b1, "R9 irq_done raised");
      // R6 later pulse ignored
      hold(1'b1, 7); hold(1'b0, 4);
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd10, "R6 later pulse ignored");
      // R9 write-one clear
      wr(2'd3, 16'h0001);
      check_reg(2'd3, 16'h0001, 16'h0000, "R9 done cleared");
      check_bit(irq_done, 1'b0, "R9 irq_done dropped");

      // R3 low width, R7 repeat mode
      hold(1'b1, 5);
      wr(2'd0, ctl(0, 2, 1, 1, 0, 1));
      settle();
      hold(1'b0, 6); hold(1'b1, 4);
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd6, "R3 low width");
      hold(1'b0, 9); hold(1'b1, 4);
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd9, "R7 second result without restart");
      check_reg(2'd3, 16'h0004, 16'h0004, "R7 still busy");
      // R12 stop
      wr(2'd0, ctl(0, 2, 1, 1, 0, 0));
      hold(1'b0, 3); hold(1'b1, 4);
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd9, "R12 stopped block ignores edges");
      check_reg(2'd3, 16'h0004, 16'h0000, "R12 busy clear after stop");

      // R4 rise-to-rise
      hold(1'b0, 4);
      wr(2'd0, ctl(0, 3, 0, 1, 0, 1));
      settle();
      for (int i = 0; i < 3; i++) begin hold(1'b1, 3); hold(1'b0, 5); end
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd8, "R4 interval");

      // R5 divided span, ratio 3 then ratio 0
      wr(2'd1, 16'd3);
      wr(2'd0, ctl(0, 4, 0, 1, 0, 1));
      settle();
      for (int i = 0; i < 5; i++) begin hold(1'b1, 2); hold(1'b0, 4); end
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd18, "R5 span of three rising edges");
      wr(2'd1, 16'd0);
      wr(2'd0, ctl(0, 4, 0, 1, 0, 1));
      settle();
      for (int i = 0; i < 3; i++) begin hold(1'b1, 2); hold(1'b0, 4); end
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd6, "R5 zero ratio acts as one");

      // R10 alternate-cycle tick, R13 equal edge delay
      wr(2'd0, ctl(1, 1, 0, 1, 0, 1));
      settle();
      hold(1'b1, 10); hold(1'b0, 4);
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd5, "R10 half-rate tick");

      // R11 reload timer, reload 4
      wr(2'd2, 16'd4);
      wr(2'd3, 16'h0003);
      wr(2'd0, ctl(0, 0, 1, 1, 0, 1));
      k = 0;
      while (!irq_done && k < 50) begin
         @(negedge clk);
         k++;
      end
      total++;
      if (k != 5) begin
         bad++;
         $display("FAIL R11 timer period: actual %0d expected %0d", k, 5);
      end
      wr(2'd0, ctl(0, 0, 0, 1, 0, 0));
      check_reg(2'd2, 16'hFFFF, 16'd4, "R11 reload kept in data buffer");

      // R8 overflow wrap
      wr(2'd3, 16'h0003);
      wr(2'd0, ctl(0, 1, 0, 0, 1, 1));
      settle();
      hold(1'b1, 65539); hold(1'b0, 4);
      settle();
      check_reg(2'd2, 16'hFFFF, 16'd3, "R8 wrapped result");
      check_reg(2'd3, 16'h0003, 16'h0003, "R8 overflow and done flags");
      check_bit(irq_ovf, 1'b1, "R8 irq_ovf raised");
      wr(2'd3, 16'h0002);
      check_bit(irq_ovf, 1'b0, "R8 overflow cleared");

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule